// File: doc/BRIEF.md
# Multi-format serial frame transmitter

The block turns one character at a time into a serial frame on a single data line. Each frame has a low start bit, then 7, 8 or 9 data bits sent least significant bit first, an optional parity bit, and one or two high stop bits. In the 9-bit format the eight buffer bits are all data and the ninth bit comes from a separate input. Parity is never inserted in that format. In asynchronous operation each bit lasts a fixed number of ticks of a 16x oversampling strobe, and the final stop bit can be cut to seven-eighths of a bit.

In synchronous operation one bit lasts one period of a shift clock, and the data line changes on that clock's rising edge. The shift clock is either produced by the block from the oversampling strobe and driven out, or taken from an external clock pin through a synchronizer. A one-character holding buffer sits in front of the shift register and reports when it is empty. The next character can therefore be loaded while the current one is on the line, and frames follow each other without a gap. The format, mode and stop settings are captured when a character moves from the buffer into the shift register.

Top module: `ser_frame_tx`

## Requirements
- R1: While reset is asserted and afterwards until the first load, `txd_o` is 1, `tx_empty_o` is 1 and `sclk_o` is 0.
- R2: A frame is a 0 start bit, then the data bits least significant first, then optional parity, then stop bits at 1. A `char_len_i` of 00 gives 8 data bits. The line returns to 1 when the frame ends.
- R3: In asynchronous mode (`sync_mode_i`=0) a full bit lasts 16 cycles in which `tick16_i` is 1. Cycles without a tick do not advance the frame.
- R4: A `char_len_i` of 01 sends `data_i[6:0]`. A code of 10 sends `data_i[7:0]` followed by `bit9_i` as the ninth data bit. Code 11 behaves like 00.
- R5: With `parity_en_i`=1 in the 7-bit or 8-bit format, one parity bit follows the data. The `parity_sel_i` codes are: 00 odd (data plus parity hold an odd count of ones), 01 even, 10 always 1, 11 always 0.
- R6: In the 9-bit format no parity bit is sent, whatever `parity_en_i` is.
- R7: `two_stop_i`=1 sends two stop bits, and 0 sends one.
- R8: In asynchronous mode with `short_stop_i`=1 the last stop bit lasts 14 ticks. With two stop bits, the first one stays 16 ticks. In synchronous mode the option has no effect.
- R9: A load accepted at a clock edge drops `tx_empty_o` after that edge. A waiting character moves into the shift register one cycle after its load when the line is idle, or at the end of the current frame. That move raises `tx_empty_o`, and the start bit appears in the same cycle with no idle gap.
- R10: A `load_i` while the buffer is full is ignored, and that character is never sent.
- R11: In synchronous mode with `ext_clk_sel_i`=0, `sclk_o` is 1 for the first 8 ticks of each bit and 0 for the last 8. Every change of `txd_o` during the frame coincides with a rising edge of `sclk_o`. `sclk_o` is 0 when idle.
- R12: In synchronous mode with `ext_clk_sel_i`=1, the frame starts and each bit advances on a rising edge of `ext_clk_i`. The edge is seen three clock edges after the pin changes (two synchronizer stages plus an edge register). `sclk_o` stays 0.
- R13: Format, parity, stop and mode inputs are captured when a character enters the shift register. Changing them mid-frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | Oversampling strobe, 16 per bit |
| ext_clk_i | input | 1 | External shift clock, asynchronous |
| sync_mode_i | input | 1 | 1 selects synchronous operation |
| ext_clk_sel_i | input | 1 | In synchronous mode, 1 takes the shift clock from `ext_clk_i` |
| char_len_i | input | 2 | Data length code: 01 seven, 00 eight, 10 nine |
| parity_en_i | input | 1 | Enable parity in 7-bit and 8-bit formats |
| parity_sel_i | input | 2 | Parity kind: 00 odd, 01 even, 10 mark, 11 space |
| two_stop_i | input | 1 | Two stop bits |
| short_stop_i | input | 1 | Shorten the final stop bit to 14 ticks |
| load_i | input | 1 | Write `data_i`/`bit9_i` into the holding buffer |
| data_i | input | DATA_W | Character |
| bit9_i | input | 1 | Ninth data bit for the 9-bit format |
| txd_o | output | 1 | Serial data, idle high |
| sclk_o | output | 1 | Generated shift clock |
| tx_empty_o | output | 1 | Holding buffer empty |

## Verification
The bench builds the block with its defaults: DATA_W of 8, OVS_TICKS of 16 and SYNC_STAGES of 2. With these the 9-bit format uses every buffer bit plus the separate ninth bit, the short stop is 14 ticks against a 16-tick full bit, and the generated shift clock has a clean 8/8 split. A three-edge latency applies to the external clock. The oversampling strobe runs every cycle, every third cycle and every second cycle. A slow external clock lets the strobe gating, the clock split and the synchronizer latency each show up as a cycle offset against the reference model.

// File: rtl/ser_frame_tx_pkg.sv
package ser_frame_tx_pkg;

  typedef enum logic [1:0] {
    CL_8   = 2'b00,
    CL_7   = 2'b01,
    CL_9   = 2'b10,
    CL_RSV = 2'b11
  } char_len_e;

  typedef enum logic [1:0] {
    PAR_ODD   = 2'b00,
    PAR_EVEN  = 2'b01,
    PAR_MARK  = 2'b10,
    PAR_SPACE = 2'b11
  } par_sel_e;

  typedef struct packed {
    logic sync;
    logic ext;
    logic short_stop;
  } tx_cfg_t;

endpackage

// File: rtl/ser_frame_tx_hold.sv
module ser_frame_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              bit9_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o,
  output logic              bit9_o
);

  logic              full_q;
  logic [DATA_W-1:0] data_q;
  logic              bit9_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
      bit9_q <= 1'b0;
    end else if (load_i && !full_q) begin
      full_q <= 1'b1;
      data_q <= data_i;
      bit9_q <= bit9_i;
    end else if (take_i) begin
      full_q <= 1'b0;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;
  assign bit9_o = bit9_q;

endmodule

// File: rtl/ser_frame_tx_fmt.sv
module ser_frame_tx_fmt
  import ser_frame_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4,
  parameter int CNT_W   = 4
) (
  input  logic [DATA_W-1:0]  data_i,
  input  logic               bit9_i,
  input  char_len_e          char_len_i,
  input  logic               parity_en_i,
  input  par_sel_e           parity_sel_i,
  input  logic               two_stop_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [CNT_W-1:0]   nbits_o
);

  logic [DATA_W:0]   word;
  logic [DATA_W-1:0] pmask;
  logic [CNT_W-1:0]  dlen;
  logic              par_on;
  logic              ones_odd;
  logic              par_bit;

  assign word = {bit9_i, data_i};

  always_comb begin
    case (char_len_i)
      CL_7: begin
        dlen  = CNT_W'(DATA_W - 1);
        pmask = {1'b0, {(DATA_W-1){1'b1}}};
      end
      CL_9: begin
        dlen  = CNT_W'(DATA_W + 1);
        pmask = '1;
      end
      default: begin
        dlen  = CNT_W'(DATA_W);
        pmask = '1;
      end
    endcase
  end

  assign par_on   = parity_en_i && (char_len_i != CL_9);
  assign ones_odd = ^(data_i & pmask);

  always_comb begin
    case (parity_sel_i)
      PAR_ODD:  par_bit = ~ones_odd;
      PAR_EVEN: par_bit = ones_odd;
      PAR_MARK: par_bit = 1'b1;
      default:  par_bit = 1'b0;
    endcase
  end

  // unused upper positions stay 1 and form the stop bits
  always_comb begin
    frame_o    = '1;
    frame_o[0] = 1'b0;
    for (int i = 0; i <= DATA_W; i++) begin
      if (CNT_W'(i) < dlen) frame_o[i+1] = word[i];
    end
    if (par_on) frame_o[dlen + CNT_W'(1)] = par_bit;
    nbits_o = CNT_W'(2) + dlen + CNT_W'(par_on) + CNT_W'(two_stop_i);
  end

endmodule

// File: rtl/ser_frame_tx_timer.sv
module ser_frame_tx_timer #(
  parameter int OVS_TICKS   = 16,
  parameter int SHORT_TICKS = 14,
  parameter int SYNC_STAGES = 2,
  localparam int TCNT_W     = $clog2(OVS_TICKS)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic ext_clk_i,
  input  logic run_i,
  input  logic restart_i,
  input  logic sync_i,
  input  logic ext_i,
  input  logic short_last_i,
  output logic step_o,
  output logic ext_rise_o,
  output logic sclk_o
);

  logic [SYNC_STAGES:0] sync_q;
  logic [TCNT_W-1:0]    cnt_q;
  logic [TCNT_W-1:0]    last_cnt;
  logic                 tick_step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-1:0], ext_clk_i};
  end

  assign ext_rise_o = sync_q[SYNC_STAGES-1] && !sync_q[SYNC_STAGES];

  assign last_cnt  = short_last_i ? TCNT_W'(SHORT_TICKS - 1) : TCNT_W'(OVS_TICKS - 1);
  assign tick_step = tick_i && (cnt_q == last_cnt);
  assign step_o    = run_i && (ext_i ? ext_rise_o : tick_step);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= '0;
    end else if (run_i && !ext_i && tick_i) begin
      cnt_q <= step_o ? '0 : cnt_q + TCNT_W'(1);
    end
  end

  // high half first so the rising edge marks each bit start
  assign sclk_o = run_i && sync_i && !ext_i && (cnt_q < TCNT_W'(OVS_TICKS / 2));

endmodule

// File: rtl/ser_frame_tx.sv
module ser_frame_tx
  import ser_frame_tx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS_TICKS   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick16_i,
  input  logic              ext_clk_i,
  input  logic              sync_mode_i,
  input  logic              ext_clk_sel_i,
  input  logic [1:0]        char_len_i,
  input  logic              parity_en_i,
  input  logic [1:0]        parity_sel_i,
  input  logic              two_stop_i,
  input  logic              short_stop_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              bit9_i,
  output logic              txd_o,
  output logic              sclk_o,
  output logic              tx_empty_o
);

  localparam int SHORT_TICKS = OVS_TICKS * 7 / 8;
  localparam int FRAME_W     = DATA_W + 4;
  localparam int CNT_W       = $clog2(FRAME_W + 1);

  logic              buf_full;
  logic [DATA_W-1:0] buf_data;
  logic              buf_bit9;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   nbits;

  logic               active_q;
  logic [FRAME_W-1:0] sr_q;
  logic [CNT_W-1:0]   idx_q;
  logic [CNT_W-1:0]   nbits_q;
  tx_cfg_t            cfg_q;

  logic step, ext_rise, live_ext, last_bit, frame_end, xfer, short_last;

  ser_frame_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .data_i (data_i),
    .bit9_i (bit9_i),
    .take_i (xfer),
    .full_o (buf_full),
    .data_o (buf_data),
    .bit9_o (buf_bit9)
  );

  ser_frame_tx_fmt #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_fmt (
    .data_i       (buf_data),
    .bit9_i       (buf_bit9),
    .char_len_i   (char_len_e'(char_len_i)),
    .parity_en_i  (parity_en_i),
    .parity_sel_i (par_sel_e'(parity_sel_i)),
    .two_stop_i   (two_stop_i),
    .frame_o      (frame),
    .nbits_o      (nbits)
  );

  ser_frame_tx_timer #(
    .OVS_TICKS   (OVS_TICKS),
    .SHORT_TICKS (SHORT_TICKS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick16_i),
    .ext_clk_i    (ext_clk_i),
    .run_i        (active_q),
    .restart_i    (xfer),
    .sync_i       (cfg_q.sync),
    .ext_i        (cfg_q.ext),
    .short_last_i (short_last),
    .step_o       (step),
    .ext_rise_o   (ext_rise),
    .sclk_o       (sclk_o)
  );

  assign live_ext   = sync_mode_i && ext_clk_sel_i;
  assign last_bit   = (idx_q == nbits_q - CNT_W'(1));
  assign frame_end  = active_q && step && last_bit;
  assign short_last = cfg_q.short_stop && !cfg_q.sync && last_bit;
  assign xfer       = buf_full && (active_q ? frame_end : (live_ext ? ext_rise : 1'b1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sr_q     <= '1;
      idx_q    <= '0;
      nbits_q  <= '0;
      cfg_q    <= '0;
    end else if (xfer) begin
      active_q <= 1'b1;
      sr_q     <= frame;
      idx_q    <= '0;
      nbits_q  <= nbits;
      cfg_q    <= '{sync: sync_mode_i, ext: live_ext, short_stop: short_stop_i};
    end else if (frame_end) begin
      active_q <= 1'b0;
    end else if (active_q && step) begin
      sr_q  <= {1'b1, sr_q[FRAME_W-1:1]};
      idx_q <= idx_q + CNT_W'(1);
    end
  end

  assign txd_o      = active_q ? sr_q[0] : 1'b1;
  assign tx_empty_o = !buf_full;

endmodule

// File: rtl/ser_frame_tx_chk.sv
module ser_frame_tx_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick16_i,
  input logic             load_i,
  input logic             txd_o,
  input logic             sclk_o,
  input logic             tx_empty_o,
  input logic             active_i,
  input logic             cfg_sync_i,
  input logic             cfg_ext_i,
  input logic [CNT_W-1:0] idx_i,
  input logic [CNT_W-1:0] nbits_i
);

  // R10
  empty_fall_needs_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_empty_o) |-> $past(load_i));

  // R9
  start_on_transfer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_empty_o) |-> !txd_o);

  // R3
  async_tick_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(txd_o) && !$past(cfg_sync_i) && !cfg_sync_i) |-> ($past(tick16_i) || $rose(tx_empty_o)));

  // R11
  sync_edge_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(txd_o) && cfg_sync_i && !cfg_ext_i && $past(cfg_sync_i) && !$past(cfg_ext_i))
      |-> $rose(sclk_o));

  // R2
  bit_index_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> (idx_i < nbits_i));

  // R12
  ext_clock_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && cfg_ext_i) |-> !sclk_o);

endmodule

bind ser_frame_tx ser_frame_tx_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick16_i   (tick16_i),
  .load_i     (load_i),
  .txd_o      (txd_o),
  .sclk_o     (sclk_o),
  .tx_empty_o (tx_empty_o),
  .active_i   (active_q),
  .cfg_sync_i (cfg_q.sync),
  .cfg_ext_i  (cfg_q.ext),
  .idx_i      (idx_q),
  .nbits_i    (nbits_q)
);

// File: tb/ser_frame_tx_bench.sv
`timescale 1ns/1ps
module ser_frame_tx_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       ext_clk = 1'b0;
  logic       sync_mode = 1'b0;
  logic       ext_sel = 1'b0;
  logic [1:0] cl = 2'b00;
  logic       pen = 1'b0;
  logic [1:0] ps = 2'b00;
  logic       two = 1'b0;
  logic       shrt = 1'b0;
  logic       load = 1'b0;
  logic [7:0] data = 8'h00;
  logic       b9 = 1'b0;
  logic       txd, sclk, empty;

  int    checks = 0;
  int    fails = 0;
  string cur_req = "R1";
  int    tick_per = 1;
  int    tdiv = 0;
  bit    ext_run = 1'b0;
  int    ediv = 0;
  bit    done = 1'b0;

  always #5 clk = ~clk;

  ser_frame_tx u_ser_frame_tx (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .tick16_i      (tick),
    .ext_clk_i     (ext_clk),
    .sync_mode_i   (sync_mode),
    .ext_clk_sel_i (ext_sel),
    .char_len_i    (cl),
    .parity_en_i   (pen),
    .parity_sel_i  (ps),
    .two_stop_i    (two),
    .short_stop_i  (shrt),
    .load_i        (load),
    .data_i        (data),
    .bit9_i        (b9),
    .txd_o         (txd),
    .sclk_o        (sclk),
    .tx_empty_o    (empty)
  );

  always @(negedge clk) begin
    tdiv = (tdiv + 1 >= tick_per) ? 0 : tdiv + 1;
    tick = (tdiv == 0);
    if (ext_run) begin
      ediv++;
      if (ediv == 5) begin
        ediv = 0;
        ext_clk = ~ext_clk;
      end
    end
  end

  // reference model
  bit       m_full = 1'b0, m_act = 1'b0, m_sync = 1'b0, m_ext = 1'b0;
  int       m_tcnt = 0;
  bit [8:0] m_word = '0;
  bit       ed0 = 1'b0, ed1 = 1'b0, ed2 = 1'b0;
  bit       q_bit[$];
  int       q_dur[$];

  task automatic build(bit [8:0] w);
    int dl, ones;
    bit p;
    dl = (cl == 2'b01) ? 7 : (cl == 2'b10) ? 9 : 8;
    q_bit.delete();
    q_dur.delete();
    q_bit.push_back(1'b0);
    for (int i = 0; i < dl; i++) q_bit.push_back(w[i]);
    if (pen && dl != 9) begin
      ones = 0;
      for (int i = 0; i < dl; i++) ones += int'(w[i]);
      case (ps)
        2'b00:   p = (ones % 2 == 0);
        2'b01:   p = (ones % 2 == 1);
        2'b10:   p = 1'b1;
        default: p = 1'b0;
      endcase
      q_bit.push_back(p);
    end
    q_bit.push_back(1'b1);
    if (two) q_bit.push_back(1'b1);
    for (int i = 0; i < q_bit.size(); i++)
      q_dur.push_back((i == q_bit.size() - 1 && shrt && !sync_mode) ? 14 : 16);
    m_sync = sync_mode;
    m_ext  = sync_mode && ext_sel;
  endtask

  always @(posedge clk) begin
    bit erise, step, was_act, full_old, xfer;
    if (!rst_n) begin
      m_full = 1'b0; m_act = 1'b0; m_tcnt = 0;
      ed0 = 1'b0; ed1 = 1'b0; ed2 = 1'b0;
      q_bit.delete(); q_dur.delete();
    end else begin
      erise = ed1 && !ed2;
      step = 1'b0; xfer = 1'b0;
      was_act = m_act; full_old = m_full;
      if (m_act) begin
        if (m_ext) step = erise;
        else if (tick) begin
          m_tcnt++;
          if (m_tcnt == q_dur[0]) step = 1'b1;
        end
        if (step) begin
          m_tcnt = 0;
          void'(q_bit.pop_front());
          void'(q_dur.pop_front());
          if (q_bit.size() == 0) m_act = 1'b0;
        end
      end
      if (full_old) xfer = was_act ? (step && !m_act) : ((sync_mode && ext_sel) ? erise : 1'b1);
      if (xfer) begin
        build(m_word);
        m_act = 1'b1;
        m_tcnt = 0;
      end
      if (load && !full_old) begin
        m_full = 1'b1;
        m_word = {b9, data};
      end else if (xfer) m_full = 1'b0;
      ed2 = ed1; ed1 = ed0; ed0 = ext_clk;
    end
  end

  always @(negedge clk) begin
    bit e_txd, e_sclk;
    if (!done) begin
      e_txd  = m_act ? q_bit[0] : 1'b1;
      e_sclk = m_act && m_sync && !m_ext && (m_tcnt < 8);
      checks++;
      if (txd !== e_txd || sclk !== e_sclk || empty !== !m_full) begin
        fails++;
        $display("FAIL %s cycle compare: txd=%b exp %b, sclk=%b exp %b, empty=%b exp %b",
                 cur_req, txd, e_txd, sclk, e_sclk, empty, !m_full);
      end
    end
  end

  task automatic expect_bit(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %b expected %b", cur_req, what, act, exp);
    end
  endtask

  task automatic send(logic [7:0] d, logic n9);
    while (!empty) @(negedge clk);
    load = 1'b1; data = d; b9 = n9;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic wait_done();
    while (m_act || m_full) @(negedge clk);
    repeat (3) @(negedge clk);
    expect_bit("idle line", txd, 1'b1);
    expect_bit("buffer empty", empty, 1'b1);
  endtask

  task automatic summary();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    expect_bit("txd in reset", txd, 1'b1);
    expect_bit("empty in reset", empty, 1'b1);
    expect_bit("sclk in reset", sclk, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_bit("txd after reset", txd, 1'b1);

    cur_req = "R2";
    tick_per = 1;
    send(8'hA5, 1'b0); wait_done();
    send(8'h01, 1'b0); wait_done();

    cur_req = "R3";
    tick_per = 3;
    send(8'h3C, 1'b0); wait_done();

    cur_req = "R4";
    cl = 2'b01; send(8'hD5, 1'b0); wait_done();
    cl = 2'b10; send(8'h96, 1'b1); wait_done();
    send(8'h6A, 1'b0); wait_done();
    cl = 2'b11; send(8'hC3, 1'b1); wait_done();

    cur_req = "R5";
    pen = 1'b1;
    for (int k = 0; k < 4; k++) begin
      ps = 2'(k);
      cl = 2'b01; send(8'h93, 1'b0); wait_done();
      cl = 2'b00; send(8'h7E, 1'b0); wait_done();
    end

    cur_req = "R6";
    cl = 2'b10; ps = 2'b10; send(8'h81, 1'b1); wait_done();
    pen = 1'b0; cl = 2'b00;

    cur_req = "R7";
    two = 1'b1; send(8'h55, 1'b0); wait_done();

    cur_req = "R8";
    shrt = 1'b1; two = 1'b0; send(8'hF0, 1'b0); wait_done();
    two = 1'b1; send(8'h0F, 1'b0); wait_done();
    two = 1'b0; shrt = 1'b0;

    cur_req = "R9";
    tick_per = 1;
    send(8'h11, 1'b0);
    send(8'h22, 1'b0);
    send(8'h33, 1'b0);
    wait_done();

    cur_req = "R10";
    while (!empty) @(negedge clk);
    load = 1'b1; data = 8'h5C;
    @(negedge clk);
    data = 8'hEE;
    @(negedge clk);
    load = 1'b0;
    wait_done();

    cur_req = "R13";
    send(8'hB7, 1'b0);
    repeat (40) @(negedge clk);
    cl = 2'b10; pen = 1'b1; two = 1'b1; shrt = 1'b1;
    wait_done();
    cl = 2'b00; pen = 1'b0; two = 1'b0; shrt = 1'b0;

    cur_req = "R11";
    tick_per = 2; sync_mode = 1'b1; ext_sel = 1'b0; shrt = 1'b1;
    send(8'h4D, 1'b0);
    send(8'hB2, 1'b0);
    wait_done();
    shrt = 1'b0;

    cur_req = "R12";
    ext_run = 1'b1; ext_sel = 1'b1;
    repeat (20) @(negedge clk);
    send(8'h9A, 1'b0);
    send(8'h65, 1'b0);
    wait_done();
    ext_run = 1'b0; sync_mode = 1'b0; ext_sel = 1'b0;
    repeat (10) @(negedge clk);
    expect_bit("sclk idle", sclk, 1'b0);

    summary();
    $finish;
  end

endmodule